// File: doc/BRIEF.md
# Console Receive Register Port

This block is the receive half of a processor console. A keyboard or serial front end hands it one character at a time with a one-cycle strobe and an error flag. The block holds the most recent character and shows software two internal registers, picked by an internal-register number on a simple read/write bus. The first register holds status and control: a read-only "character waiting" flag and a writable interrupt enable. The second register holds the character and a read-only fault flag.

Software consumes a character by reading the data register. That read clears the waiting flag as a side effect. The interrupt request is a level that is high whenever a character is waiting and interrupts are enabled. It therefore rises both when a character arrives with the enable already set and when software sets the enable while a character is already waiting. `reg_rdata` always shows the register chosen by `reg_sel`. Side effects happen only when `reg_rd` or `reg_wr` is high during a clock edge.

Top module: `cnsl_rx_top`

## Requirements
- R1: After reset the waiting flag and the interrupt enable are 0, `irq` is 0, and both registers read 0.
- R2: A cycle with `key_valid` high sets the waiting flag (status bit 7) and stores `key_data` in data bits 7:0. Both are visible in the cycle that follows.
- R3: A cycle with `reg_rd` high and `reg_sel` = 0x21 returns the held character and fault flag, and clears the waiting flag after that edge.
- R4: The fault flag (data bit 15) is updated on each arrival. It is set to 1 when `key_err` is high or when the arrival is an overrun.
- R5: An arrival while the waiting flag is 1, with no data read in the same cycle, is an overrun. The new character replaces the old one.
- R6: A write with `reg_sel` = 0x20 loads the interrupt enable from `reg_wdata` bit 6, and the enable reads back at status bit 6.
- R7: `irq` is high exactly when the waiting flag and the enable are both 1. With the enable set, an arrival raises `irq` in the next cycle.
- R8: Setting the enable while the waiting flag is already 1 raises `irq` in the next cycle.
- R9: Writes cannot change read-only state. Writing status bit 7 does not change the waiting flag, and a write with `reg_sel` = 0x21 changes nothing.
- R10: A data read and an arrival in the same cycle leave the waiting flag at 1, hold the new character, and do not flag an overrun.
- R11: Status bits other than 7 and 6, data bits other than 15 and 7:0, and every unmapped register number read as 0.
- R12: Reading the status register does not clear the waiting flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle strobe: a received character is on key_data |
| key_data | input | 8 | Received character |
| key_err | input | 1 | Front end reports a fault on this character |
| reg_sel | input | 8 | Internal register number (0x20 status, 0x21 data) |
| reg_rd | input | 1 | Read access this cycle (side effects only) |
| reg_wr | input | 1 | Write access this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sends two characters back to back with no read between them. A design that did not track overruns would show a clean fault bit there, and one that kept the first character would return stale data. It also places a data read and an arrival in the same cycle, where a design that gives the read priority would drop the waiting flag and lose the character. The bench sets the enable late, while a character is already waiting, to catch an edge-only interrupt that would stay low. It also writes the read-only status bit and the data register, to catch a flag that software could force.

// File: rtl/cnsl_rx_pkg.sv
package cnsl_rx_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              done;
        logic              ie;
        logic              err;
        logic [CHAR_W-1:0] char;
    } rx_state_t;
endpackage

// File: rtl/cnsl_rx_decode.sv
module cnsl_rx_decode #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h21
) (
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    output logic              csr_hit,
    output logic              data_hit,
    output logic              wr_csr,
    output logic              rd_data
);
    always_comb begin
        csr_hit  = (reg_sel == CSR_ADDR);
        data_hit = (reg_sel == DATA_ADDR);
        wr_csr   = reg_wr & csr_hit;
        // A write to the data register is decoded to nothing on purpose.
        rd_data  = reg_rd & data_hit;
    end
endmodule

// File: rtl/cnsl_rx_state.sv
module cnsl_rx_state
    import cnsl_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic              key_err,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              wr_csr,
    input  logic              ie_wval,
    input  logic              rd_data,
    output rx_state_t         st_q
);
    rx_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_csr) begin
            st_d.ie = ie_wval;
        end
        if (rd_data) begin
            st_d.done = 1'b0;
        end
        // An arrival wins over a read in the same cycle.
        if (key_valid) begin
            st_d.done = 1'b1;
            st_d.char = key_char;
            st_d.err  = key_err | (st_q.done & ~rd_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cnsl_rx_rdmux.sv
module cnsl_rx_rdmux
    import cnsl_rx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DONE_BIT = 7,
    parameter int IE_BIT   = 6,
    parameter int ERR_BIT  = 15
) (
    input  logic              csr_hit,
    input  logic              data_hit,
    input  rx_state_t         st,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] csr_word;
    logic [DATA_W-1:0] data_word;

    always_comb begin
        csr_word                = '0;
        csr_word[DONE_BIT]      = st.done;
        csr_word[IE_BIT]        = st.ie;
        data_word               = '0;
        data_word[CHAR_W-1:0]   = st.char;
        data_word[ERR_BIT]      = st.err;
        rdata = csr_hit  ? csr_word  :
                data_hit ? data_word : '0;
    end
endmodule

// File: rtl/cnsl_rx_top.sv
module cnsl_rx_top
    import cnsl_rx_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h21,
    parameter int                DONE_BIT  = 7,
    parameter int                IE_BIT    = 6,
    parameter int                ERR_BIT   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_data,
    input  logic              key_err,
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic      csr_hit;
    logic      data_hit;
    logic      wr_csr;
    logic      rd_data;
    rx_state_t st_q;
    logic      unused_wdata;

    assign unused_wdata = ^reg_wdata;

    cnsl_rx_decode #(
        .ADDR_W   (ADDR_W),
        .CSR_ADDR (CSR_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_decode (
        .reg_sel (reg_sel),
        .reg_rd  (reg_rd),
        .reg_wr  (reg_wr),
        .csr_hit (csr_hit),
        .data_hit(data_hit),
        .wr_csr  (wr_csr),
        .rd_data (rd_data)
    );

    cnsl_rx_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_err  (key_err),
        .key_char (key_data),
        .wr_csr   (wr_csr),
        .ie_wval  (reg_wdata[IE_BIT]),
        .rd_data  (rd_data),
        .st_q     (st_q)
    );

    cnsl_rx_rdmux #(
        .DATA_W  (DATA_W),
        .DONE_BIT(DONE_BIT),
        .IE_BIT  (IE_BIT),
        .ERR_BIT (ERR_BIT)
    ) u_rdmux (
        .csr_hit (csr_hit),
        .data_hit(data_hit),
        .st      (st_q),
        .rdata   (reg_rdata)
    );

    assign irq = st_q.done & st_q.ie;
endmodule

// File: rtl/cnsl_rx_chk.sv
module cnsl_rx_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h21,
    parameter int                IE_BIT    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic [ADDR_W-1:0] reg_sel,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              done,
    input logic              ie
);
    AST_ARRIVE_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> done); // R2

    AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == DATA_ADDR && !key_valid) |=> !done); // R3

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq); // R7

    AST_IRQ_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && ie && !(reg_wr && reg_sel == CSR_ADDR)) |=> irq); // R7

    AST_IRQ_LATE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == CSR_ADDR && reg_wdata[IE_BIT] && done) |=> irq); // R8

    AST_DONE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !key_valid && !(reg_rd && reg_sel == DATA_ADDR)) |=> $stable(done)); // R9

    AST_SAME_CYCLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && reg_rd && reg_sel == DATA_ADDR) |=> done); // R10
endmodule

bind cnsl_rx_top cnsl_rx_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CSR_ADDR (CSR_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .IE_BIT   (IE_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_valid(key_valid),
    .reg_sel  (reg_sel),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .done     (st_q.done),
    .ie       (st_q.ie)
);

// File: tb/cnsl_rx_top_tb.sv
module cnsl_rx_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CSR  = 8'h20;
    localparam logic [7:0] DATA = 8'h21;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        key_valid;
    logic [7:0]  key_data;
    logic        key_err;
    logic [7:0]  reg_sel;
    logic        reg_rd;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnsl_rx_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_data (key_data),
        .key_err  (key_err),
        .reg_sel  (reg_sel),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every task starts and ends 1 time unit after a rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
        key_valid = 0; reg_rd = 0; reg_wr = 0; key_err = 0;
    endtask

    task automatic key(input logic [7:0] c, input logic e);
        key_valid = 1; key_data = c; key_err = e;
        tick();
    endtask

    task automatic peek(input logic [7:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #2;
        v = reg_rdata;
    endtask

    task automatic rd(input logic [7:0] sel, output logic [31:0] v);
        reg_sel = sel; reg_rd = 1;
        #2;
        v = reg_rdata;
        tick();
    endtask

    task automatic wr(input logic [7:0] sel, input logic [31:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(CSR, v);    chk("R1 status", v, 32'h0);
        peek(DATA, v);   chk("R1 data", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        peek(8'h05, v);  chk("R11 unmapped", v, 32'h0);
    endtask

    task automatic t_arrive_and_read();
        logic [31:0] v;
        key(8'h41, 0);
        peek(CSR, v);  chk("R2 done set", v, 32'h80);
        peek(DATA, v); chk("R2 char", v, 32'h41);
        chk("R7 irq off without ie", {31'h0, irq}, 32'h0);
        rd(CSR, v);    chk("R12 status read value", v, 32'h80);
        peek(CSR, v);  chk("R12 done kept", v, 32'h80);
        rd(DATA, v);   chk("R3 read value", v, 32'h41);
        peek(CSR, v);  chk("R3 done cleared", v, 32'h0);
    endtask

    task automatic t_error_and_overrun();
        logic [31:0] v;
        key(8'h55, 1);
        peek(DATA, v); chk("R4 key_err flag", v, 32'h8055);
        rd(DATA, v);
        key(8'h10, 0);
        peek(DATA, v); chk("R4 flag cleared on clean char", v, 32'h0010);
        key(8'h20, 0);
        peek(DATA, v); chk("R5 overrun replaces char", v, 32'h8020);
        rd(DATA, v);
        peek(CSR, v);  chk("R3 done cleared after overrun", v, 32'h0);
    endtask

    task automatic t_interrupts();
        logic [31:0] v;
        wr(CSR, 32'h40);
        peek(CSR, v);  chk("R6 ie readback", v, 32'h40);
        chk("R7 irq idle", {31'h0, irq}, 32'h0);
        key(8'h33, 0);
        chk("R7 irq on arrival", {31'h0, irq}, 32'h1);
        rd(DATA, v);
        chk("R7 irq drops after read", {31'h0, irq}, 32'h0);
        wr(CSR, 32'h0);
        key(8'h44, 0);
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        wr(CSR, 32'h40);
        chk("R8 irq on late enable", {31'h0, irq}, 32'h1);
        wr(CSR, 32'h0);
        chk("R6 ie cleared", {31'h0, irq}, 32'h0);
        rd(DATA, v);
    endtask

    task automatic t_read_only();
        logic [31:0] v;
        wr(CSR, 32'h80);
        peek(CSR, v);  chk("R9 done not writable", v, 32'h0);
        wr(DATA, 32'h1234);
        peek(DATA, v); chk("R9 data not writable", v, 32'h0044);
        wr(CSR, 32'hFFFF_FFFF);
        peek(CSR, v);  chk("R11 only ie reads back", v, 32'h40);
        wr(CSR, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        key(8'h61, 0);
        reg_sel = DATA; reg_rd = 1;
        key_valid = 1; key_data = 8'h62; key_err = 0;
        #2;
        chk("R10 read returns old char", reg_rdata, 32'h0061);
        tick();
        peek(CSR, v);  chk("R10 done stays set", v, 32'h80);
        peek(DATA, v); chk("R10 new char, no overrun", v, 32'h0062);
        rd(DATA, v);
    endtask

    initial begin
        key_valid = 0; key_data = 0; key_err = 0;
        reg_sel = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        t_reset();
        t_arrive_and_read();
        t_error_and_overrun();
        t_interrupts();
        t_read_only();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule